// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter for Complex Baseband

This block sits right after a CIC decimator. It gives the final spectral shaping and removes energy outside the wanted band from a stream of complex baseband samples. Each cycle with `in_valid` high carries one signed 16-bit I/Q pair. The block produces one filtered signed 16-bit I/Q pair for every two pairs it accepts, so the output rate is half the input rate. The I and Q paths use the same coefficients and do not interact.

The response is a 31-tap symmetric halfband. Every even-distance tap around the centre is zero. The centre tap is one half, so it costs a shift and no multiply. The mirrored samples that share an odd-distance coefficient are added together before the multiply. As a result each channel uses eight multipliers. Coefficients are fixed when the design is elaborated.

The filter sums the products at full precision. It then rounds the result to nearest and clamps it to the 16-bit range. The delay from the input that completes a window to its output is a fixed number of cycles, given by the localparam `LATENCY`.

Top module: `hb_decim2`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes low, `out_valid` is 0 and both outputs are 0. Reset clears the pairing phase and the sample history, so the first two accepted samples after reset produce the first output, computed as if all earlier samples were zero.
- R2: Accepted inputs are numbered 0, 1, 2, … from reset. Exactly one output is produced for each odd-numbered input (1, 3, 5, …). Even-numbered inputs produce none.
- R3: `out_valid` rises at the third rising edge after the edge that accepted the odd-numbered input (`LATENCY` = 3).
- R4: `out_valid` is high for one cycle only. `out_i` and `out_q` change only in a cycle where `out_valid` is high, and they hold their value otherwise.
- R5: For the output at odd index n, y = Σ h[k]·x[n−k] over k = 0..30, with coefficients scaled by 2^17. The taps are: h[15] = 65536; h[15±d] = 0 for even d > 0; h[15±d] = C[(d−1)/2] for odd d. The default C[0..7] is 40000, −12000, 6500, −3800, 2200, −1200, 600, 468.
- R6: With the default coefficients the DC gain is exactly one. Once a constant input has filled the window, the output equals that input.
- R7: Rounding computes floor((acc + 2^16) / 2^17), which rounds to nearest with exact halves going toward +∞ (58.5 → 59, −58.5 → −58).
- R8: Results above 32767 come out as 32767. Results below −32768 come out as −32768.
- R9: The I and Q paths filter independently with the same response.
- R10: Cycles with `in_valid` low change neither the history nor the phase. A stream with gaps gives the same outputs as the same stream sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pair present this cycle |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_valid | output | 1 | One-cycle strobe for a new output pair |
| out_i | output | 16 | Filtered in-phase output, signed |
| out_q | output | 16 | Filtered quadrature output, signed |

## Verification
The hardest cases to reach from the ports are exact rounding ties and saturation of the accumulator. Both need the full 31-sample window to line up with the coefficient signs.

For ties, the stimulus sends an impulse of amplitude 16384 on an odd-numbered input. Every output then shows one tap divided by eight. Two of those taps land on exact halves, and the Q path carries the negated impulse, so both directions of a tie are observed. Sending the impulse on an even-numbered input exposes only the centre tap.

For saturation, the stimulus fills a window with full-scale samples whose signs match each tap. This drives the sum past both limits.

A reset in the middle of a pair, after the history holds large samples, checks that the phase and the history both restart.

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int W    = 16,
  parameter int CW   = 18,
  parameter int NTAP = 31,
  parameter int CF   = 17,
  parameter logic [((NTAP+1)/4)*CW-1:0] COEF = {18'(468), 18'(600), 18'(-1200), 18'(2200),
                                                18'(-3800), 18'(6500), 18'(-12000), 18'(40000)}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam int NU      = (NTAP + 1) / 4;
  localparam int MID     = (NTAP - 1) / 2;
  localparam int PW      = W + 1;
  localparam int MW      = PW + CW;
  localparam int AW      = MW + $clog2(NU) + 2;
  localparam int LATENCY = 3;
  localparam logic signed [AW-1:0] HI   = AW'(2 ** (W - 1) - 1);
  localparam logic signed [AW-1:0] LO   = ~HI;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CF - 1);

  logic phase, s1, s2, s3, ov;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      ov    <= 1'b0;
    end else begin
      if (in_valid) phase <= ~phase;
      s1 <= in_valid & phase;
      s2 <= s1;
      s3 <= s2;
      ov <= s3;
    end
  end

  assign out_valid = ov;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [W-1:0]  din;
    logic signed [W-1:0]  dl [NTAP];
    logic signed [PW-1:0] pre [NU];
    logic signed [MW-1:0] prod [NU];
    logic signed [W-1:0]  ctr;
    logic signed [AW-1:0] cterm, acc, rnd;
    logic signed [W-1:0]  q, y;

    assign din = (c == 0) ? in_i : in_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < NTAP; k++) dl[k] <= '0;
      end else if (in_valid) begin
        dl[0] <= din;
        for (int k = 1; k < NTAP; k++) dl[k] <= dl[k-1];
      end
    end

    always_ff @(posedge clk) begin
      if (s1) begin
        for (int j = 0; j < NU; j++)
          pre[j] <= PW'(dl[MID-1-2*j]) + PW'(dl[MID+1+2*j]);
        ctr <= dl[MID];
      end
      if (s2) begin
        for (int j = 0; j < NU; j++)
          prod[j] <= MW'(pre[j]) * MW'($signed(COEF[j*CW +: CW]));
        cterm <= AW'(ctr) <<< (CF - 1);
      end
    end

    always_comb begin
      acc = cterm + HALF;
      for (int j = 0; j < NU; j++) acc = acc + AW'(prod[j]);
    end

    assign rnd = acc >>> CF;
    assign q   = (rnd > HI) ? HI[W-1:0] : (rnd < LO) ? LO[W-1:0] : rnd[W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)  y <= '0;
      else if (s3) y <= q;
    end
  end

  assign out_i = g_ch[0].y;
  assign out_q = g_ch[1].y;
endmodule

module hb_decim2_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_i,
  input logic [W-1:0] out_q
);
  logic       odd;
  logic [3:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd  <= 1'b0;
      hist <= '0;
    end else begin
      if (in_valid) odd <= ~odd;
      hist <= {hist[2:0], in_valid & odd};
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));

  p_one_per_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[3]);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind hb_decim2 hb_decim2_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/hb_decim2_bench.sv
`timescale 1ns/1ps
module hb_decim2_bench;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #10 clk = ~clk;

  hb_decim2 u_hb_decim2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int total = 0, bad = 0, nx = 0, n_out = 0;
  bit done = 0;
  int xi [128], xq [128];
  int cap_i [64], cap_q [64];
  localparam int HK [8] = '{40000, -12000, 6500, -3800, 2200, -1200, 600, 468};
  localparam int IMP_I [16] = '{59, 75, -150, 275, -475, 813, -1500, 5000,
                                5000, -1500, 813, -475, 275, -150, 75, 59};
  localparam int IMP_Q [16] = '{-58, -75, 150, -275, 475, -812, 1500, -5000,
                                -5000, 1500, -812, 475, -275, 150, -75, -58};
  localparam int TBL_N = 20;
  localparam int TBL [TBL_N][3] = '{
    '{1000, -2000, 0}, '{-3000, 500, 1}, '{12000, 7000, 0}, '{-15000, -9000, 2},
    '{32000, 31000, 0}, '{-32768, 100, 0}, '{250, -250, 1}, '{7, -7, 0},
    '{20000, -20000, 3}, '{-1, 1, 0}, '{9999, 1234, 0}, '{-8888, -4321, 1},
    '{30000, 0, 0}, '{0, 30000, 0}, '{-30000, -30000, 2}, '{16384, 8192, 0},
    '{-16384, -8192, 0}, '{5, 6, 1}, '{-12345, 23456, 0}, '{32767, -32768, 0}
  };

  always @(negedge clk) begin
    if (out_valid && n_out < 64) begin
      cap_i[n_out] = out_i;
      cap_q[n_out] = out_q;
      n_out++;
    end
  end

  function automatic longint tap(int k);
    int d;
    d = k - 15;
    if (d == 0) return 65536;
    if (d % 2 == 0) return 0;
    if (d < 0) d = -d;
    return HK[(d - 1) / 2];
  endfunction

  function automatic int model(int n, bit qside);
    longint s;
    s = 0;
    for (int k = 0; k < 31; k++)
      if (n - k >= 0) s += tap(k) * (qside ? xq[n-k] : xi[n-k]);
    s = (s + 65536) >>> 17;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nx = 0;
    n_out = 0;
  endtask

  task automatic push(int i, int q);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    xi[nx] = i;
    xq[nx] = q;
    nx++;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic compare_all(string tag);
    idle(6);
    chk(n_out == nx / 2, {tag, " R2 output count"}, n_out, nx / 2);
    for (int m = 0; m < n_out; m++) begin
      chk(cap_i[m] == model(2*m + 1, 0), {tag, " R5 I"}, cap_i[m], model(2*m + 1, 0));
      chk(cap_q[m] == model(2*m + 1, 1), {tag, " R9 Q"}, cap_q[m], model(2*m + 1, 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    bit ov [6];
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(out_i == 16'sd0 && out_q == 16'sd0, "R1 reset data", out_i, 0);
    do_reset();

    // R5 R9 R10: table stream with idle gaps against the tap model
    for (int t = 0; t < TBL_N; t++) begin
      push(TBL[t][0], TBL[t][1]);
      if (TBL[t][2] > 0) idle(TBL[t][2]);
    end
    compare_all("table R10");

    // R6: constant input after the window fills
    do_reset();
    for (int t = 0; t < 40; t++) push(1234, -777);
    idle(6);
    chk(cap_i[15] == 1234, "R6 dc I first full", cap_i[15], 1234);
    chk(cap_i[19] == 1234, "R6 dc I last", cap_i[19], 1234);
    chk(cap_q[19] == -777, "R6 dc Q last", cap_q[19], -777);

    // R5 R7: impulse on an odd input, halves in both directions
    do_reset();
    push(0, 0);
    push(16384, -16384);
    for (int t = 0; t < 32; t++) push(0, 0);
    idle(6);
    chk(n_out == 17, "R2 impulse count", n_out, 17);
    for (int m = 0; m < 16; m++) begin
      chk(cap_i[m] == IMP_I[m], "R7 impulse I", cap_i[m], IMP_I[m]);
      chk(cap_q[m] == IMP_Q[m], "R7 impulse Q", cap_q[m], IMP_Q[m]);
    end
    chk(cap_i[16] == 0, "R5 impulse tail", cap_i[16], 0);

    // R5: impulse on an even input only meets the centre tap
    do_reset();
    push(16384, -16384);
    for (int t = 0; t < 33; t++) push(0, 0);
    idle(6);
    for (int m = 0; m < 17; m++) begin
      chk(cap_i[m] == ((m == 7) ? 8192 : 0), "R5 centre I", cap_i[m], (m == 7) ? 8192 : 0);
      chk(cap_q[m] == ((m == 7) ? -8192 : 0), "R5 centre Q", cap_q[m], (m == 7) ? -8192 : 0);
    end

    // R8: sign-matched full-scale window
    do_reset();
    for (int idx = 0; idx < 32; idx++) begin
      longint hv;
      hv = (idx == 0) ? 0 : tap(31 - idx);
      push(hv > 0 ? 32767 : (hv < 0 ? -32768 : 1000),
           hv > 0 ? -32768 : (hv < 0 ? 32767 : 0));
    end
    idle(6);
    chk(cap_i[15] == 32767, "R8 sat high", cap_i[15], 32767);
    chk(cap_q[15] == -32768, "R8 sat low", cap_q[15], -32768);
    compare_all("sat R8");

    // R3 R4: strobe timing
    do_reset();
    push(7000, 7000);
    push(7000, 7000);
    for (int t = 1; t <= 5; t++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ov[t] = out_valid;
    end
    chk(ov[1] == 0 && ov[2] == 0 && ov[3] == 0, "R3 early strobe", ov[3], 0);
    chk(ov[4] == 1, "R3 strobe at latency", ov[4], 1);
    chk(ov[5] == 0, "R4 single pulse", ov[5], 0);

    // R4: one unpaired input leaves outputs unchanged
    v = out_i;
    push(-5000, -5000);
    idle(6);
    chk(out_i == 16'(v) && out_valid == 1'b0, "R4 hold", out_i, v);
    chk(n_out == 1, "R2 unpaired input", n_out, 1);

    // R1: reset mid-pair clears phase and history
    do_reset();
    push(30000, 30000);
    push(30000, 30000);
    push(-30000, -30000);
    do_reset();
    push(20000, -20000);
    push(30000, 10000);
    compare_all("midreset R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule